// File: doc/BRIEF.md
# IDE Interrupt Status and Clear Unit

This block gathers the two interrupt causes of a single-channel IDE host controller: a request from the attached ATA device and a bus error raised by the DMA engine while it moves data. Each cause arrives as a one-cycle pulse. The block latches each cause into a sticky pending bit. It gates the pending bits with per-source enable bits to drive one level-sensitive interrupt line. When a DMA bus error is accepted, it also records the faulting bus address.

Software reaches the block through a plain 32-bit register port with byte offsets. A write is a single cycle with `reg_wr` high, and the block never stalls it. A read is combinational on `reg_off`. The port carries no handshake because every access completes in the cycle it is presented. A driver sets the enables once at start-up through a write-one-to-set word. When it services an interrupt, it reads the status word, reads the error address if the bus-error bit is set, and writes ones to the clear word for the bits it has handled.

Top module: `ide_irq_unit`

## Requirements
- R1: After reset, both pending bits and both enable bits are 0, the captured address is 0 and `irq_out` is low.
- R2: A pulse on `dev_irq_pulse` sets pending bit 0 and a pulse on `dma_err_pulse` sets pending bit 1. Both take effect from the next cycle, and the bits stay set until they are cleared.
- R3: A write to offset 0x1C clears every pending bit whose `reg_wdata` bit is 1 (bit 0 = device, bit 1 = bus error). Bits written as 0 are unchanged.
- R4: When a source pulse coincides with a clear of the same bit, the bit ends up set.
- R5: A write to offset 0x14 sets each enable bit whose `reg_wdata` bit is 1 and leaves the others unchanged. A read of 0x14 returns the enables in bits [1:0].
- R6: `irq_out` is high exactly when some pending bit has its enable bit set. The pending bits are latched and read back whatever the enable bits are.
- R7: A `dma_err_pulse` that arrives while pending bit 1 is clear captures `dma_err_addr`. Its bits [31:0] read at offset 0x00 and its upper bits read at offset 0x04, zero-extended.
- R8: A `dma_err_pulse` that arrives while pending bit 1 is already set leaves the captured address unchanged.
- R9: Writes to offsets 0x00, 0x04 and 0x0C change no state. Reads of offsets other than 0x00, 0x04, 0x0C and 0x14 return 0.
- R10: A read of offset 0x0C returns pending bit 0 (device) in bit 0 and pending bit 1 (bus error) in bit 1, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_irq_pulse | input | 1 | One-cycle interrupt request from the ATA device |
| dma_err_pulse | input | 1 | One-cycle bus error from the DMA engine |
| dma_err_addr | input | ADDR_W | Bus address of the failing DMA transfer, valid with `dma_err_pulse` |
| reg_wr | input | 1 | Register write strobe |
| reg_off | input | OFF_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_off` |
| irq_out | output | 1 | Interrupt request line |

## Verification
The hardest situation to reach is a bus-error pulse in the same cycle as a clear write to the bus-error bit. In that cycle the pulse must win and the captured address must not move, because an error was already pending when the pulse arrived. The directed part of the bench lines up the write strobe and the pulse in one cycle, with a fresh address on the bus that would be visible if the capture were wrongly taken. A long random phase then drives pulses and clears together at high rates, so both coincidences recur many times. A behavioural model compares the interrupt line and the read data every clock.

// File: rtl/ide_irq_pkg.sv
package ide_irq_pkg;
  localparam int unsigned NSRC       = 2;
  localparam int unsigned SRC_DEV    = 0;
  localparam int unsigned SRC_BUSERR = 1;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned WORD_LSB   = 2;
  localparam int unsigned WORD_BITS  = 3;

  typedef enum logic [WORD_BITS-1:0] {
    WD_ERR_LO = 3'd0,
    WD_ERR_HI = 3'd1,
    WD_STATUS = 3'd3,
    WD_EN_SET = 3'd5,
    WD_CLEAR  = 3'd7
  } word_e;

  typedef struct packed {
    logic en_set;
    logic clear;
  } wr_strobe_t;
endpackage

// File: rtl/ide_irq_decode.sv
module ide_irq_decode
  import ide_irq_pkg::*;
#(
  parameter int unsigned OFF_W = 5
) (
  input  logic                 wr_i,
  input  logic [OFF_W-1:0]     off_i,
  output logic                 hit_o,
  output logic [WORD_BITS-1:0] word_o,
  output wr_strobe_t           strb_o
);
  localparam int unsigned SPAN_BITS = WORD_LSB + WORD_BITS;

  logic [OFF_W-1:0] upper;

  assign upper  = off_i >> SPAN_BITS;
  assign hit_o  = (upper == '0);
  assign word_o = off_i[SPAN_BITS-1:WORD_LSB];

  always_comb begin
    strb_o = '0;
    if (wr_i && hit_o) begin
      strb_o.en_set = (word_o == WD_EN_SET);
      strb_o.clear  = (word_o == WD_CLEAR);
    end
  end
endmodule

// File: rtl/ide_irq_src.sv
module ide_irq_src (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_i,
  input  logic clr_i,
  input  logic en_set_i,
  output logic pend_o,
  output logic en_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_o <= 1'b0;
    end else if (pulse_i) begin
      pend_o <= 1'b1;
    end else if (clr_i) begin
      pend_o <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_o <= 1'b0;
    end else if (en_set_i) begin
      en_o <= 1'b1;
    end
  end

  // R2 R4
  pulse_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_i |=> pend_o);

  // R3
  clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !pulse_i) |=> !pend_o);

  // R2
  pend_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && !clr_i) |=> pend_o);

  // R5
  en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_o |=> en_o);
endmodule

// File: rtl/ide_irq_addr_cap.sv
module ide_irq_addr_cap #(
  parameter int unsigned ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_i,
  input  logic              pending_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic take;

  assign take = err_i && !pending_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_o <= '0;
    end else if (take) begin
      addr_o <= addr_i;
    end
  end

  // R7
  first_err_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_i && !pending_i) |=> (addr_o == $past(addr_i)));

  // R8
  later_err_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pending_i |=> $stable(addr_o));
endmodule

// File: rtl/ide_irq_unit.sv
module ide_irq_unit
  import ide_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned OFF_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_irq_pulse,
  input  logic              dma_err_pulse,
  input  logic [ADDR_W-1:0] dma_err_addr,
  input  logic              reg_wr,
  input  logic [OFF_W-1:0]  reg_off,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq_out
);
  localparam int unsigned EXT_W = 2 * REG_W;

  logic [NSRC-1:0]      src_pulse;
  logic [NSRC-1:0]      pend;
  logic [NSRC-1:0]      en;
  logic [ADDR_W-1:0]    cap_addr;
  logic [EXT_W-1:0]     cap_ext;
  logic                 hit;
  logic [WORD_BITS-1:0] word;
  wr_strobe_t           strb;

  assign src_pulse[SRC_DEV]    = dev_irq_pulse;
  assign src_pulse[SRC_BUSERR] = dma_err_pulse;

  ide_irq_decode #(.OFF_W(OFF_W)) u_dec (
    .wr_i   (reg_wr),
    .off_i  (reg_off),
    .hit_o  (hit),
    .word_o (word),
    .strb_o (strb)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    ide_irq_src u_src (
      .clk      (clk),
      .rst_n    (rst_n),
      .pulse_i  (src_pulse[g]),
      .clr_i    (strb.clear && reg_wdata[g]),
      .en_set_i (strb.en_set && reg_wdata[g]),
      .pend_o   (pend[g]),
      .en_o     (en[g])
    );
  end

  ide_irq_addr_cap #(.ADDR_W(ADDR_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .err_i     (dma_err_pulse),
    .pending_i (pend[SRC_BUSERR]),
    .addr_i    (dma_err_addr),
    .addr_o    (cap_addr)
  );

  assign cap_ext = EXT_W'(cap_addr);
  assign irq_out = |(pend & en);

  always_comb begin
    reg_rdata = '0;
    if (hit) begin
      case (word)
        WD_ERR_LO: reg_rdata = cap_ext[REG_W-1:0];
        WD_ERR_HI: reg_rdata = cap_ext[EXT_W-1:REG_W];
        WD_STATUS: reg_rdata = REG_W'(pend);
        WD_EN_SET: reg_rdata = REG_W'(en);
        default:   reg_rdata = '0;
      endcase
    end
  end

  // R6
  irq_needs_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ($countones(pend) != 0 && $countones(en) != 0));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!irq_out && $countones(pend) == 0));
endmodule

// File: tb/test_ide_irq_unit.sv
module test_ide_irq_unit;
  localparam int ADDR_W = 64;
  localparam int OFF_W  = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              dev_irq_pulse = 1'b0;
  logic              dma_err_pulse = 1'b0;
  logic [ADDR_W-1:0] dma_err_addr = '0;
  logic              reg_wr = 1'b0;
  logic [OFF_W-1:0]  reg_off = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic              irq_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  ide_irq_unit #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) i_ide_irq_unit (
    .clk(clk), .rst_n(rst_n), .dev_irq_pulse(dev_irq_pulse),
    .dma_err_pulse(dma_err_pulse), .dma_err_addr(dma_err_addr),
    .reg_wr(reg_wr), .reg_off(reg_off), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  // behavioural reference
  bit [1:0]  m_pend = 0;
  bit [1:0]  m_en   = 0;
  bit [63:0] m_addr = 0;

  function automatic bit [31:0] m_read(input bit [OFF_W-1:0] off);
    case (off)
      5'h00:   return m_addr[31:0];
      5'h04:   return m_addr[63:32];
      5'h0C:   return {30'd0, m_pend};
      5'h14:   return {30'd0, m_en};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = 0; m_en = 0; m_addr = 0;
    end else begin
      bit [1:0] np;
      np = m_pend;
      if (reg_wr && reg_off == 5'h1C) np = np & ~reg_wdata[1:0];
      if (reg_wr && reg_off == 5'h14) m_en = m_en | reg_wdata[1:0];
      if (dev_irq_pulse) np[0] = 1'b1;
      if (dma_err_pulse) begin
        if (!m_pend[1]) m_addr = dma_err_addr;
        np[1] = 1'b1;
      end
      m_pend = np;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      chk(irq_out == |(m_pend & m_en), "R6 irq line", irq_out, |(m_pend & m_en));
      chk(reg_rdata == m_read(reg_off), "R10 read data", reg_rdata, m_read(reg_off));
    end
  end

  task automatic cycle();
    @(posedge clk);
    #7;
  endtask

  task automatic rd(input bit [OFF_W-1:0] off, input bit [31:0] exp, input string req);
    reg_off = off;
    #1;
    chk(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  task automatic wr(input bit [OFF_W-1:0] off, input bit [31:0] d);
    reg_wr = 1; reg_off = off; reg_wdata = d;
    cycle();
    reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic dev_pulse();
    dev_irq_pulse = 1; cycle(); dev_irq_pulse = 0;
  endtask

  task automatic err_pulse(input bit [63:0] a);
    dma_err_pulse = 1; dma_err_addr = a; cycle(); dma_err_pulse = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    finish_run();
  end

  initial begin
    repeat (3) cycle();
    rst_n = 1;
    cycle();
    // R1 reset state
    chk(irq_out == 0, "R1 irq after reset", irq_out, 0);
    rd(5'h0C, 0, "R1 status after reset");
    rd(5'h14, 0, "R1 enables after reset");
    rd(5'h00, 0, "R1 addr lo after reset");
    rd(5'h04, 0, "R1 addr hi after reset");

    // R2 device pulse, R6 masked
    dev_pulse();
    rd(5'h0C, 32'h1, "R2 device pending");
    chk(irq_out == 0, "R6 masked source keeps line low", irq_out, 0);
    cycle();
    rd(5'h0C, 32'h1, "R2 device bit sticky");

    // R5 enables
    wr(5'h14, 32'h1);
    rd(5'h14, 32'h1, "R5 enable bit0");
    chk(irq_out == 1, "R6 enabled device raises line", irq_out, 1);
    wr(5'h14, 32'h0);
    rd(5'h14, 32'h1, "R5 zero write keeps enables");
    wr(5'h14, 32'h2);
    rd(5'h14, 32'h3, "R5 both enables");

    // R7 first bus error capture
    err_pulse(64'h1234_5678_9ABC_DEF0);
    rd(5'h0C, 32'h3, "R2 bus error pending");
    rd(5'h00, 32'h9ABC_DEF0, "R7 addr low word");
    rd(5'h04, 32'h1234_5678, "R7 addr high word");

    // R8 second error while pending
    err_pulse(64'hAAAA_BBBB_CCCC_DDDD);
    rd(5'h00, 32'h9ABC_DEF0, "R8 addr low kept");
    rd(5'h04, 32'h1234_5678, "R8 addr high kept");

    // R3 partial clear
    wr(5'h1C, 32'h1);
    rd(5'h0C, 32'h2, "R3 clear bit0 only");
    chk(irq_out == 1, "R6 bus error still drives line", irq_out, 1);

    // R4 coincident clear and error pulse
    reg_wr = 1; reg_off = 5'h1C; reg_wdata = 32'h2;
    dma_err_pulse = 1; dma_err_addr = 64'h5555_6666_7777_8888;
    cycle();
    reg_wr = 0; reg_wdata = 0; dma_err_pulse = 0;
    rd(5'h0C, 32'h2, "R4 pulse wins over clear");
    rd(5'h00, 32'h9ABC_DEF0, "R8 coincident pulse keeps addr");

    // R3 full clear
    wr(5'h1C, 32'h3);
    rd(5'h0C, 32'h0, "R3 clear both");
    chk(irq_out == 0, "R6 line drops after clear", irq_out, 0);

    // R9 writes to read-only words, unmapped reads
    wr(5'h0C, 32'h3);
    rd(5'h0C, 32'h0, "R9 status write ignored");
    wr(5'h00, 32'hFFFF_FFFF);
    wr(5'h04, 32'hFFFF_FFFF);
    rd(5'h00, 32'h9ABC_DEF0, "R9 addr low write ignored");
    rd(5'h04, 32'h1234_5678, "R9 addr high write ignored");
    rd(5'h08, 32'h0, "R9 unmapped read");
    rd(5'h10, 32'h0, "R9 unmapped read");
    rd(5'h1C, 32'h0, "R9 clear word reads zero");

    // R7 capture again after clear
    err_pulse(64'h0000_0001_0000_0002);
    rd(5'h00, 32'h2, "R7 new capture low");
    rd(5'h04, 32'h1, "R7 new capture high");
    wr(5'h1C, 32'h3);

    // random phase, checked against the model every clock
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      dev_irq_pulse = (r % 3) == 0;
      dma_err_pulse = (r % 4) == 0;
      dma_err_addr  = {$urandom, $urandom};
      reg_wr        = r < 45;
      case ($urandom_range(0, 5))
        0: reg_off = 5'h1C;
        1: reg_off = 5'h1C;
        2: reg_off = 5'h0C;
        3: reg_off = 5'h00;
        4: reg_off = 5'h04;
        default: reg_off = 5'h14;
      endcase
      reg_wdata = {30'd0, 2'($urandom)};
      cycle();
    end
    dev_irq_pulse = 0; dma_err_pulse = 0; reg_wr = 0;
    cycle();
    finish_run();
  end
endmodule